// File: doc/BRIEF.md
# Conflict-Allocating Instruction Cache

This block sits in the fetch path of a DSP core with two memory buses: a data bus and a program-memory bus. The program-memory bus carries instruction fetches, and it can also carry one data operand. Each instruction usually needs two operands plus its own instruction word, so two buses cannot supply all three in one cycle. The cache removes that bottleneck for code that repeats. It keeps an instruction only when that instruction's fetch collided with a data access on the program-memory bus.

On a later pass through the same code, the instruction comes from the cache in the same cycle its address is presented. Both buses are then free to carry the two operands. A miss with no collision goes straight over the bus without a stall and is not stored.

A colliding miss works in two cycles. In the first cycle the data access keeps the bus and the fetch stalls. In the second cycle the instruction is read over the bus, delivered to the core and written into the cache. The cache has a parameterised number of sets, with two ways per set. Each way has a valid bit, and each set has one least-recently-used bit. A flush input empties the cache in one cycle, and a freeze input stops new allocations.

Top module: `conflict_icache`

## Requirements
- R1: When a fetch hits, `instr_o` carries the cached word, and `hit_o` and `instr_valid_o` are high in the same cycle. `pm_req_o` and `stall_o` stay low in that cycle.
- R2: When a fetch hits while `conflict_i` is high, there is no stall and no program-memory request.
- R3: When a fetch misses with `conflict_i` low, `pm_req_o` is high in the same cycle, `pm_addr_o` equals the fetch address, `instr_o` equals `pm_rdata_i`, and there is no stall. Nothing is allocated, so the next fetch of that address misses again.
- R4: When a fetch misses with `conflict_i` high, that cycle has `stall_o` high, `pm_req_o` low and `instr_valid_o` low. The next cycle has `pm_req_o` high with the held address, `instr_o` equal to `pm_rdata_i`, and `instr_valid_o` high. From the cycle after that, a fetch of the same address hits.
- R5: The set index is the low log2(SETS) bits of the word address, and each set has two ways. Allocation goes to an invalid way first, otherwise to the least-recently-used way. Both a hit and an allocation make the way they touch the most recently used.
- R6: A cycle with `flush_i` high invalidates every entry at its closing edge. A refill that completes in that same cycle is not kept.
- R7: While `freeze_i` is high, a conflicting miss still stalls and still delivers its word, but nothing is allocated.
- R8: After reset every entry is invalid. With `fetch_req_i` low, `stall_o`, `pm_req_o`, `instr_valid_o` and `hit_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_req_i | input | 1 | Fetch request this cycle |
| fetch_addr_i | input | AW | Instruction word address; held by the core while stalled |
| conflict_i | input | 1 | A data access claims the program-memory bus this cycle |
| flush_i | input | 1 | Invalidate all entries |
| freeze_i | input | 1 | Block allocation |
| pm_req_o | output | 1 | Instruction read on the program-memory bus |
| pm_addr_o | output | AW | Address of that read |
| pm_rdata_i | input | IW | Word returned by the program-memory bus in the same cycle |
| instr_o | output | IW | Instruction to the core |
| instr_valid_o | output | 1 | `instr_o` is valid this cycle |
| hit_o | output | 1 | The instruction came from the cache |
| stall_o | output | 1 | The fetch is held for one cycle |

## Verification
A hit and a non-conflicting miss produce their result in the same cycle as the fetch. The bench therefore samples one time unit after driving the inputs at the falling edge. A conflicting miss shows the stall in its first cycle and the bus read plus the delivered word in the second cycle. The allocation only becomes visible as a hit on a fetch made after the following rising edge. Each fetch therefore takes its own window of cycles, and checks on the cache contents are always made by a later fetch, never in the cycle of the write.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [0:0] {
    ST_LOOKUP = 1'b0,
    ST_REFILL = 1'b1
  } icc_state_e;
endpackage

// File: rtl/icc_tag_array.sv
module icc_tag_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic [WAYS-1:0]  way_hit_o,
  output logic [WAYS-1:0]  set_valid_o,
  input  logic             wr_en_i,
  input  logic [WAYS-1:0]  wr_way_oh_i,
  input  logic             flush_i,
  input  logic             freeze_i
);
  logic [WAYS-1:0][SETS-1:0]            valid_q;
  logic [WAYS-1:0][SETS-1:0][TAG_W-1:0] tag_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign set_valid_o[w] = valid_q[w][rd_idx_i];
    assign way_hit_o[w]   = valid_q[w][rd_idx_i] && (tag_q[w][rd_idx_i] == rd_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[w] <= '0;
      end else if (flush_i) begin
        valid_q[w] <= '0;
      end else if (wr_en_i && wr_way_oh_i[w]) begin
        valid_q[w][rd_idx_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[w] <= '0;
      end else if (wr_en_i && wr_way_oh_i[w]) begin
        tag_q[w][rd_idx_i] <= rd_tag_i;
      end
    end
  end

  // R5: a tag lives in at most one way of a set
  p_single_way_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit_o));
  // R6: flush empties the whole array
  p_flush_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  // R7: frozen cache never gains entries
  p_freeze_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !flush_i) |=> (valid_q == $past(valid_q)));
endmodule

// File: rtl/icc_data_array.sv
module icc_data_array #(
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int IDX_W = 4,
  parameter int IW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAYS-1:0]  rd_way_oh_i,
  output logic [IW-1:0]    rd_data_o,
  input  logic             wr_en_i,
  input  logic [WAYS-1:0]  wr_way_oh_i,
  input  logic [IW-1:0]    wr_data_i
);
  logic [WAYS-1:0][SETS-1:0][IW-1:0] data_q;
  logic [WAYS-1:0][IW-1:0]           masked;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[w] <= '0;
      end else if (wr_en_i && wr_way_oh_i[w]) begin
        data_q[w][idx_i] <= wr_data_i;
      end
    end
    assign masked[w] = rd_way_oh_i[w] ? data_q[w][idx_i] : '0;
  end

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < WAYS; w++) rd_data_o |= masked[w];
  end
endmodule

// File: rtl/icc_lru.sv
module icc_lru #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       set_valid_i,
  output logic [1:0]       victim_oh_o,
  input  logic             touch_i,
  input  logic             touch_way_i
);
  // lru_q[s] names the way to replace next in set s
  logic [SETS-1:0] lru_q;
  logic            victim;

  always_comb begin
    if (!set_valid_i[0])      victim = 1'b0;
    else if (!set_valid_i[1]) victim = 1'b1;
    else                      victim = lru_q[idx_i];
  end
  assign victim_oh_o = victim ? 2'b10 : 2'b01;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q[idx_i] <= ~touch_way_i;
  end

  // R5: the way just used is never the next victim
  p_mru_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (lru_q[$past(idx_i)] != $past(touch_way_i)));
endmodule

// File: rtl/icc_ctrl.sv
module icc_ctrl
  import icc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          conflict_i,
  input  logic          lookup_hit_i,
  input  logic          flush_i,
  input  logic          freeze_i,
  output logic          in_refill_o,
  output logic [AW-1:0] held_addr_o,
  output logic          stall_o,
  output logic          pm_req_o,
  output logic          alloc_o
);
  icc_state_e state_q, state_d;
  logic [AW-1:0] held_q;

  always_comb begin
    state_d  = state_q;
    stall_o  = 1'b0;
    pm_req_o = 1'b0;
    alloc_o  = 1'b0;
    unique case (state_q)
      ST_LOOKUP: begin
        if (fetch_req_i && !lookup_hit_i) begin
          if (conflict_i) begin
            stall_o = 1'b1;
            state_d = ST_REFILL;
          end else begin
            pm_req_o = 1'b1;
          end
        end
      end
      ST_REFILL: begin
        pm_req_o = 1'b1;
        alloc_o  = !freeze_i && !flush_i;
        state_d  = ST_LOOKUP;
      end
      default: state_d = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOOKUP;
      held_q  <= '0;
    end else begin
      state_q <= state_d;
      if (stall_o) held_q <= fetch_addr_i;
    end
  end

  assign in_refill_o = (state_q == ST_REFILL);
  assign held_addr_o = held_q;

  // R4: a stall lasts exactly one cycle and is followed by the bus read
  p_stall_then_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (pm_req_o && !stall_o));
  p_read_held_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (held_addr_o == $past(fetch_addr_i)));
endmodule

// File: rtl/conflict_icache.sv
module conflict_icache #(
  parameter int AW   = 16,
  parameter int IW   = 32,
  parameter int SETS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          conflict_i,
  input  logic          flush_i,
  input  logic          freeze_i,
  output logic          pm_req_o,
  output logic [AW-1:0] pm_addr_o,
  input  logic [IW-1:0] pm_rdata_i,
  output logic [IW-1:0] instr_o,
  output logic          instr_valid_o,
  output logic          hit_o,
  output logic          stall_o
);
  localparam int WAYS  = 2;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = AW - IDX_W;

  logic [AW-1:0]    look_addr;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  way_hit, set_valid, victim_oh, touch_oh;
  logic             in_refill, any_hit, alloc;
  logic [AW-1:0]    held_addr;
  logic [IW-1:0]    cache_word;

  assign look_addr = in_refill ? held_addr : fetch_addr_i;
  assign idx       = look_addr[IDX_W-1:0];
  assign tag       = look_addr[AW-1:IDX_W];
  assign any_hit   = |way_hit;
  assign hit_o     = fetch_req_i && !in_refill && any_hit;
  assign touch_oh  = alloc ? victim_oh : way_hit;

  icc_tag_array #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .rd_idx_i(idx), .rd_tag_i(tag),
    .way_hit_o(way_hit), .set_valid_o(set_valid),
    .wr_en_i(alloc), .wr_way_oh_i(victim_oh),
    .flush_i, .freeze_i
  );

  icc_data_array #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .IW(IW)) u_data (
    .clk_i, .rst_ni,
    .idx_i(idx), .rd_way_oh_i(way_hit), .rd_data_o(cache_word),
    .wr_en_i(alloc), .wr_way_oh_i(victim_oh), .wr_data_i(pm_rdata_i)
  );

  icc_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk_i, .rst_ni,
    .idx_i(idx), .set_valid_i(set_valid), .victim_oh_o(victim_oh),
    .touch_i(hit_o || alloc), .touch_way_i(touch_oh[1])
  );

  icc_ctrl #(.AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .fetch_req_i, .fetch_addr_i, .conflict_i,
    .lookup_hit_i(any_hit), .flush_i, .freeze_i,
    .in_refill_o(in_refill), .held_addr_o(held_addr),
    .stall_o, .pm_req_o, .alloc_o(alloc)
  );

  assign pm_addr_o     = in_refill ? held_addr : fetch_addr_i;
  assign instr_o       = hit_o ? cache_word : pm_rdata_i;
  assign instr_valid_o = hit_o || pm_req_o;

  // R1/R2: a hit never uses the bus or stalls
  p_hit_free_bus_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (!pm_req_o && !stall_o));
  // R8: no fetch, no activity
  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_req_i && !in_refill) |-> !(pm_req_o || stall_o || hit_o));
endmodule

// File: tb/conflict_icache_tb_top.sv
module conflict_icache_tb_top;
  localparam int AW = 16;
  localparam int IW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req = 1'b0, conflict = 1'b0, flush = 1'b0, freeze = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic pm_req, instr_valid, hit, stall;
  logic [AW-1:0] pm_addr;
  logic [IW-1:0] pm_rdata, instr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5a3c, ~a};
  endfunction

  assign pm_rdata = mem_word(pm_addr);

  conflict_icache #(.AW(AW), .IW(IW), .SETS(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_addr_i(fetch_addr), .conflict_i(conflict),
    .flush_i(flush), .freeze_i(freeze),
    .pm_req_o(pm_req), .pm_addr_o(pm_addr), .pm_rdata_i(pm_rdata),
    .instr_o(instr), .instr_valid_o(instr_valid), .hit_o(hit), .stall_o(stall)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // One fetch; samples in each cycle the result is due
  task automatic do_fetch(input logic [AW-1:0] a, input bit conf, input bit exp_hit,
                          input bit flush_in_refill, input string rq);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a; conflict = conf;
    #1;
    if (exp_hit) begin
      chk(hit == 1'b1, rq, "hit", 32'(hit), 32'd1);
      chk(!pm_req && !stall, rq, "bus idle on hit", {30'd0, pm_req, stall}, 32'd0);
      chk(instr_valid && instr == mem_word(a), rq, "cached word", instr, mem_word(a));
    end else if (!conf) begin
      chk(hit == 1'b0, rq, "miss", 32'(hit), 32'd0);
      chk(pm_req && !stall && pm_addr == a, rq, "bus read", 32'(pm_addr), 32'(a));
      chk(instr_valid && instr == mem_word(a), rq, "bus word", instr, mem_word(a));
    end else begin
      chk(stall && !pm_req && !instr_valid, rq, "stall cycle",
          {29'd0, stall, pm_req, instr_valid}, 32'd4);
      @(negedge clk);
      conflict = 1'b0; flush = flush_in_refill;
      #1;
      chk(!stall && pm_req && pm_addr == a, rq, "refill read", 32'(pm_addr), 32'(a));
      chk(instr_valid && !hit && instr == mem_word(a), rq, "refill word", instr, mem_word(a));
    end
    @(negedge clk);
    fetch_req = 1'b0; conflict = 1'b0; flush = 1'b0;
  endtask

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          conf;
    logic          exp_hit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 1'b0, 1'b0},  // R3 plain miss
    '{16'h0010, 1'b0, 1'b0},  // R3 still not allocated
    '{16'h0010, 1'b1, 1'b0},  // R4 conflict miss allocates way0
    '{16'h0010, 1'b0, 1'b1},  // R1 hit
    '{16'h0010, 1'b1, 1'b1},  // R2 hit under conflict
    '{16'h0020, 1'b1, 1'b0},  // R5 same set, free way1
    '{16'h0010, 1'b0, 1'b1},  // R5 way0 becomes MRU
    '{16'h0030, 1'b1, 1'b0},  // R5 evicts 0x0020
    '{16'h0010, 1'b0, 1'b1},  // R5 kept
    '{16'h0030, 1'b0, 1'b1},  // R5 new line
    '{16'h0020, 1'b0, 1'b0},  // R5 evicted
    '{16'h0025, 1'b1, 1'b0},  // R4 other set
    '{16'h0025, 1'b0, 1'b1}   // R1 hit other set
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!stall && !pm_req && !instr_valid && !hit, "R8", "idle after reset",
        {28'd0, stall, pm_req, instr_valid, hit}, 32'd0);

    for (int i = 0; i < NV; i++)
      do_fetch(VECS[i].addr, VECS[i].conf, VECS[i].exp_hit, 1'b0, "R1-table");

    // R6: flush empties lines allocated before
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    do_fetch(16'h0010, 1'b0, 1'b0, 1'b0, "R6");
    do_fetch(16'h0025, 1'b0, 1'b0, 1'b0, "R6");

    // R6: refill finishing under flush is discarded
    do_fetch(16'h0050, 1'b1, 1'b0, 1'b1, "R6");
    do_fetch(16'h0050, 1'b0, 1'b0, 1'b0, "R6");

    // R7: frozen conflict miss stalls but does not allocate
    freeze = 1'b1;
    do_fetch(16'h0041, 1'b1, 1'b0, 1'b0, "R7");
    do_fetch(16'h0041, 1'b0, 1'b0, 1'b0, "R7");
    freeze = 1'b0;
    do_fetch(16'h0041, 1'b1, 1'b0, 1'b0, "R7");
    do_fetch(16'h0041, 1'b0, 1'b1, 1'b0, "R7");

    // R8: reset empties the cache
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_fetch(16'h0041, 1'b0, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule